// File: doc/BRIEF.md
# Per-ID Ordered Write-Response Buffer

This block sits on the write-response path between a fast memory and the requester that issued the writes. It holds each single-beat response until an outside timing model allows it to leave. Responses that share an AXI ID still leave in the order their address requests were made. At address time the requester side makes a reservation. The buffer always shows which internal identifier (a storage cell index) that reservation will take, and it claims the cell in the same cycle as the handshake. Because of this, a response that arrives later always has room.

The cells form one shared pool. Each ID keeps its own singly linked list through that pool. A list has a newest-reserved pointer, a next-to-fill pointer and an oldest pointer, plus two counts: reserved-but-empty and stored-not-sent. The ID is not stored with the payload. It is known from the list that holds the cell. The outgoing response sits in a one-cycle register stage, and the next candidate is fetched from the link after the oldest cell, so output can run every cycle.

The release enable of a cell is tested twice: once when the cell is loaded into the output stage, and again while it is presented. If the enable drops in between, the valid signal is withdrawn. When a response leaves, the block emits a one-hot pulse naming its internal identifier, and the cell goes back to the pool.

Top module: `ordered_rsp_buf`

## Requirements
- R1: After reset no response is offered, `released_o` is zero, a reservation is accepted and the advertised internal identifier is 0.
- R2: A reservation is accepted exactly when at least one of the NCELL cells is free. The advertised identifier `rsv_iid_o` is always a free cell, and that cell is owned from the handshake cycle onward.
- R3: `in_ready_o` is high exactly when the ID on `in_id_i` has at least one reservation that has not yet received its response.
- R4: For every ID, responses leave in the order they arrived, each tagged with that ID on `out_id_o`.
- R5: A response is offered only while `rel_en_i` bit number (its internal identifier) is high in that same cycle. If the bit drops, `out_valid_o` drops in the same cycle.
- R6: On each output handshake `released_o` has exactly one bit set, at the bit index equal to the internal identifier of the departing response. In every other cycle it is all zeros.
- R7: While a response is offered, not accepted, and its enable stays high, the same ID and data are offered on the next cycle.
- R8: When the enables are high and `out_ready_i` is high, a list of stored responses drains at one response per cycle with no gap.
- R9: Reservation, response arrival and release may occur in the same cycle in any combination, and each one takes effect.
- R10: A cell freed by release can be reserved again, so the full pool of NCELL cells is available again once every response has left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsv_valid_i | input | 1 | Address request wants a reservation |
| rsv_id_i | input | IW | AXI ID of the address request |
| rsv_ready_o | output | 1 | A free cell exists |
| rsv_iid_o | output | CW | Internal identifier the next reservation receives |
| in_valid_i | input | 1 | Response from memory is valid |
| in_id_i | input | IW | AXI ID of the arriving response |
| in_data_i | input | DW | Response payload |
| in_ready_o | output | 1 | The arriving ID has a reserved empty cell |
| rel_en_i | input | NCELL | Per-internal-identifier release enable |
| out_valid_o | output | 1 | Response offered to the requester |
| out_ready_i | input | 1 | Requester accepts |
| out_id_o | output | IW | AXI ID of the offered response |
| out_data_o | output | DW | Offered payload |
| released_o | output | NCELL | One-hot pulse naming the internal identifier that left |

## Verification
The bench fills the whole pool for each ID in turn. A buffer that miscounts free cells would accept a ninth reservation or refuse the eighth. The bench then drains the pool with everything enabled, and a design that got the link-ahead fetch wrong would insert idle cycles or send an entry twice. Directed steps hold an entry while ready is low and then drop its enable. This catches an output stage that switches entries while stalled, or one that keeps offering after its enable is gone. A long random phase stacks reservation, arrival and release for the same ID into single cycles. Mishandling the empty-list and last-reservation corner cases would then corrupt links and show up as out-of-order or wrong data for an ID.

// File: rtl/ordered_rsp_buf.sv
module ordered_rsp_buf #(
  parameter int NCELL = 8,
  parameter int NID   = 4,
  parameter int DW    = 8,
  localparam int CW   = (NCELL > 1) ? $clog2(NCELL) : 1,
  localparam int IW   = (NID > 1) ? $clog2(NID) : 1,
  localparam int NW   = $clog2(NCELL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rsv_valid_i,
  input  logic [IW-1:0]    rsv_id_i,
  output logic             rsv_ready_o,
  output logic [CW-1:0]    rsv_iid_o,
  input  logic             in_valid_i,
  input  logic [IW-1:0]    in_id_i,
  input  logic [DW-1:0]    in_data_i,
  output logic             in_ready_o,
  input  logic [NCELL-1:0] rel_en_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [IW-1:0]    out_id_o,
  output logic [DW-1:0]    out_data_o,
  output logic [NCELL-1:0] released_o
);

  logic [NCELL-1:0] busy_q;
  logic [CW-1:0]    link_q [NCELL];
  logic [DW-1:0]    pay_q  [NCELL];
  logic [CW-1:0]    newest_q [NID];
  logic [CW-1:0]    fill_q   [NID];
  logic [CW-1:0]    oldest_q [NID];
  logic [NW-1:0]    nwait_q  [NID];
  logic [NW-1:0]    nheld_q  [NID];

  logic          ov_q;
  logic [CW-1:0] ocell_q;
  logic [IW-1:0] oid_q;
  logic [DW-1:0] odat_q;

  logic          free_any;
  logic [CW-1:0] free_idx;
  logic          rsv_fire, in_fire, hs;
  logic [CW-1:0] head_c [NID];
  logic [NW-1:0] left_c [NID];
  logic [NID-1:0] cand_c;
  logic          sel_v;
  logic [IW-1:0] sel_id;
  logic [CW-1:0] sel_cell;
  logic [NW:0]   wait_after, total_after;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = NCELL - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        free_any = 1'b1;
        free_idx = CW'(i);
      end
    end
  end

  assign rsv_ready_o = free_any;
  assign rsv_iid_o   = free_idx;
  assign rsv_fire    = rsv_valid_i & free_any;
  assign in_ready_o  = nwait_q[in_id_i] != '0;
  assign in_fire     = in_valid_i & in_ready_o;
  assign out_valid_o = ov_q & rel_en_i[ocell_q];
  assign out_id_o    = oid_q;
  assign out_data_o  = odat_q;
  assign hs          = out_valid_o & out_ready_i;
  assign released_o  = hs ? (NCELL'(1) << ocell_q) : '0;

  always_comb begin
    for (int k = 0; k < NID; k++) begin
      if (hs && oid_q == IW'(k)) begin
        head_c[k] = link_q[ocell_q];
        left_c[k] = nheld_q[k] - NW'(1);
      end else begin
        head_c[k] = oldest_q[k];
        left_c[k] = nheld_q[k];
      end
      cand_c[k] = (left_c[k] != '0) && rel_en_i[head_c[k]];
    end
    sel_v  = 1'b0;
    sel_id = '0;
    for (int k = NID - 1; k >= 0; k--) begin
      if (cand_c[k]) begin
        sel_v  = 1'b1;
        sel_id = IW'(k);
      end
    end
    if (ov_q && !hs && cand_c[oid_q]) sel_id = oid_q;
    sel_cell = head_c[sel_id];
  end

  assign wait_after  = {1'b0, nwait_q[rsv_id_i]}
                     - ((in_fire && in_id_i == rsv_id_i) ? (NW+1)'(1) : '0);
  assign total_after = {1'b0, nwait_q[rsv_id_i]} + {1'b0, nheld_q[rsv_id_i]}
                     - ((hs && oid_q == rsv_id_i) ? (NW+1)'(1) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= '0;
      ov_q    <= 1'b0;
      ocell_q <= '0;
      oid_q   <= '0;
      odat_q  <= '0;
      for (int i = 0; i < NCELL; i++) begin
        link_q[i] <= '0;
        pay_q[i]  <= '0;
      end
      for (int k = 0; k < NID; k++) begin
        newest_q[k] <= '0;
        fill_q[k]   <= '0;
        oldest_q[k] <= '0;
        nwait_q[k]  <= '0;
        nheld_q[k]  <= '0;
      end
    end else begin
      ov_q    <= sel_v;
      ocell_q <= sel_cell;
      oid_q   <= sel_id;
      odat_q  <= pay_q[sel_cell];
      for (int k = 0; k < NID; k++) begin
        nwait_q[k] <= nwait_q[k]
                    + NW'(rsv_fire && rsv_id_i == IW'(k))
                    - NW'(in_fire && in_id_i == IW'(k));
        nheld_q[k] <= nheld_q[k]
                    + NW'(in_fire && in_id_i == IW'(k))
                    - NW'(hs && oid_q == IW'(k));
      end
      if (hs) begin
        busy_q[ocell_q] <= 1'b0;
        oldest_q[oid_q] <= link_q[ocell_q];
      end
      if (in_fire) begin
        pay_q[fill_q[in_id_i]] <= in_data_i;
        fill_q[in_id_i]        <= link_q[fill_q[in_id_i]];
      end
      if (rsv_fire) begin
        busy_q[free_idx]   <= 1'b1;
        newest_q[rsv_id_i] <= free_idx;
        if (total_after != '0) link_q[newest_q[rsv_id_i]] <= free_idx;
        if (wait_after == '0)  fill_q[rsv_id_i] <= free_idx;
        if (total_after == '0) oldest_q[rsv_id_i] <= free_idx;
      end
    end
  end

  int total_c;
  always_comb begin
    total_c = 0;
    for (int k = 0; k < NID; k++) total_c += int'(nwait_q[k]) + int'(nheld_q[k]);
  end

  assert_pool_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(busy_q) == total_c);

  assert_claim_same_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsv_fire |=> busy_q[$past(rsv_iid_o)]);

  assert_offer_has_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> nheld_q[oid_q] != '0);

  assert_offer_is_oldest_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_q |-> ocell_q == oldest_q[oid_q]);

  assert_release_owned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |-> busy_q[ocell_q]);

  assert_hold_when_stalled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_q && !hs && cand_c[oid_q]) |=> ($stable(oid_q) && $stable(odat_q) && $stable(ocell_q)));

endmodule

// File: tb/ordered_rsp_buf_tb_top.sv
module ordered_rsp_buf_tb_top;
  localparam int NC = 8;
  localparam int NI = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          rsv_valid = 0;
  logic [1:0]    rsv_id = '0;
  logic          rsv_ready;
  logic [2:0]    rsv_iid;
  logic          in_valid = 0;
  logic [1:0]    in_id = '0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic [NC-1:0] rel_en = '0;
  logic          out_valid;
  logic          out_ready = 0;
  logic [1:0]    out_id;
  logic [DW-1:0] out_data;
  logic [NC-1:0] released;

  ordered_rsp_buf #(.NCELL(NC), .NID(NI), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rsv_valid_i(rsv_valid), .rsv_id_i(rsv_id), .rsv_ready_o(rsv_ready), .rsv_iid_o(rsv_iid),
    .in_valid_i(in_valid), .in_id_i(in_id), .in_data_i(in_data), .in_ready_o(in_ready),
    .rel_en_i(rel_en), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_id_o(out_id), .out_data_o(out_data), .released_o(released)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;
  bit busy_m [NC];
  int pend_m [NI];
  int dq [NI][$];
  int iq [NI][$];
  bit last_valid;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int used();
    int n = 0;
    for (int i = 0; i < NC; i++) n += busy_m[i];
    return n;
  endfunction

  task automatic step();
    bit [NC-1:0] e;
    int iid;
    #1;
    last_valid = out_valid;
    chk(rsv_ready == (used() < NC), "R2 ready", rsv_ready, used() < NC);
    if (rsv_ready) chk(!busy_m[rsv_iid], "R2 free iid", rsv_iid, -1);
    chk(in_ready == (pend_m[in_id] > 0), "R3 in_ready", in_ready, pend_m[in_id] > 0);
    if (out_valid) begin
      chk(iq[out_id].size() > 0, "R4 nonempty", iq[out_id].size(), 1);
      if (iq[out_id].size() > 0) begin
        iid = iq[out_id][0];
        chk(rel_en[iid], "R5 enable", rel_en[iid], 1);
        chk(out_data == dq[out_id][0], "R4 order", out_data, dq[out_id][0]);
        if (out_ready) begin
          e = '0; e[iid] = 1'b1;
          chk(released == e, "R6 onehot", released, e);
          void'(iq[out_id].pop_front());
          void'(dq[out_id].pop_front());
          busy_m[iid] = 0;
        end else chk(released == '0, "R6 idle", released, 0);
      end
    end else chk(released == '0, "R6 idle", released, 0);
    if (in_valid && in_ready) begin
      dq[in_id].push_back(in_data);
      pend_m[in_id]--;
    end
    if (rsv_valid && rsv_ready) begin
      busy_m[rsv_iid] = 1;
      iq[rsv_id].push_back(rsv_iid);
      pend_m[rsv_id]++;
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    rsv_valid = 0; in_valid = 0; out_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int run;
    bit [DW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!out_valid, "R1 valid", out_valid, 0);
    chk(rsv_ready, "R1 ready", rsv_ready, 1);
    chk(rsv_iid == 0, "R1 iid", rsv_iid, 0);
    chk(released == '0, "R1 released", released, 0);
    @(negedge clk);

    // R8 R10: pool sweep, one ID at a time
    for (int s = 0; s < NI; s++) begin
      quiet(); rel_en = '0;
      for (int j = 0; j < NC + 1; j++) begin
        rsv_valid = 1; rsv_id = 2'(s);
        if (j == NC) begin
          #1; chk(!rsv_ready, "R2 full refuse", rsv_ready, 0);
          @(negedge clk);
        end else step();
      end
      rsv_valid = 0;
      for (int j = 0; j < NC; j++) begin
        in_valid = 1; in_id = 2'(s); in_data = DW'(s * 16 + j);
        step();
      end
      in_valid = 0; rel_en = '1; out_ready = 1;
      run = 0;
      for (int j = 0; j < NC + 4; j++) begin
        step();
        if (last_valid) run++;
      end
      chk(run == NC, "R8 back to back", run, NC);
      chk(used() == 0 && rsv_ready, "R10 pool free", used(), 0);
    end

    // R5 R7 directed
    quiet(); rel_en = '0;
    rsv_valid = 1; rsv_id = 2; step();
    rsv_valid = 0; in_valid = 1; in_id = 2; in_data = 8'hA5; step();
    in_valid = 0; step(); step();
    chk(!out_valid, "R5 blocked", out_valid, 0);
    rel_en = '1; step();
    held = out_data;
    for (int j = 0; j < 4; j++) begin
      step();
      chk(last_valid && out_data == held, "R7 hold", out_data, held);
    end
    rel_en = '0; #1;
    chk(!out_valid, "R5 drop", out_valid, 0);
    @(negedge clk);
    rel_en = '1; out_ready = 1;
    step(); step(); step();

    // R9 random mix
    for (int c = 0; c < 4000; c++) begin
      rsv_valid = 1'($urandom % 2); rsv_id = 2'($urandom);
      in_valid = 1'($urandom % 2); in_id = 2'($urandom); in_data = DW'($urandom);
      out_ready = 1'($urandom % 2); rel_en = NC'($urandom);
      step();
    end

    // drain
    rsv_valid = 0; rel_en = '1; out_ready = 1;
    for (int c = 0; c < 200; c++) begin
      in_valid = 0;
      for (int k = 0; k < NI; k++) if (pend_m[k] > 0) begin
        in_valid = 1; in_id = 2'(k); in_data = DW'($urandom);
      end
      step();
    end
    chk(used() == 0, "R10 drained", used(), 0);
    for (int k = 0; k < NI; k++) chk(dq[k].size() == 0, "R4 all out", dq[k].size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule